// File: doc/BRIEF.md
# Debug Halt, Breakpoint, Step and Flow-Trace Unit

This unit sits beside one processor core and gives an external debugger control over it through a small register file. In a full chip, a serial test access port would drive that register file. Here it is a plain read/write strobe interface. The core side is reduced to three strobes: a fetch address strobe, an instruction-retired strobe and a change-of-flow strobe that carries the target address. There is also a software-breakpoint strobe and a core reset indication.

The unit can halt the core in three ways: on request, when an enabled address comparator matches a fetch, or when the core reports a software breakpoint. Halting drops two registered clock enables, one for the core and one for the core's peripherals. While halted, the debugger can write an opcode that is handed straight to the instruction register, so no memory fetch is needed. It can also resume the core for a set number of retired instructions. An eight-deep trace store records only the targets of taken changes of flow. When the store is full, each new target overwrites the oldest entry and a sticky flag is set. The register file stays usable while the core runs and while the core is held in reset.

Register offsets on `rg_addr`:
- 0: command register, write only.
- 1: step count.
- 2: comparator enable mask.
- 3: status.
- 4: trace pop.
- 5: opcode injection.
- 8+i: address of comparator i.

Reads return data in `rg_rdata` on the cycle after the read strobe.

Top module: `dbg_trace_step`

## Requirements
- R1: After reset the core runs and both clock enables are 1. Status reads 0, the step count reads 0, the comparator enable mask reads 0 and `inj_valid` is 0.
- R2: Writing the command register with bit 0 set halts the core. Bit 0 causes a halt even when the same write also sets bit 1. Writing it with only bit 1 set resumes the core. Both clock enables follow the halt state at the clock edge that samples the write. Status bit 0 reports the halt state.
- R3: A fetch whose address equals comparator i's address halts the core at that edge, if bit i of the enable mask is set. With that enable bit clear, or with a different address, the fetch has no effect. The comparator addresses read back at offset 8+i.
- R4: A software-breakpoint strobe while the core runs halts it.
- R5: Each change-of-flow strobe while the core runs pushes its target address into the trace store. A retire strobe alone pushes nothing. Change-of-flow strobes while halted are dropped.
- R6: A read of offset 4 pops and returns the oldest trace entry. A read of offset 4 on an empty store returns 0. Status bits 7:4 give the number of valid entries.
- R7: A push into a full store (8 entries) overwrites the oldest entry and sets status bit 2. Status bit 2 stays set until a command write with bit 3 set, which empties the store and clears status bit 2.
- R8: A command write with bit 2 set, while the step count is nonzero, resumes the core and sets status bit 1. Each retire strobe decrements the count. The retire strobe that brings the count to zero halts the core and clears status bit 1. With a step count of 0, a bit-2 command write is ignored. Retire strobes while halted do not decrement the count.
- R9: A write to offset 5 while halted produces a one-cycle `inj_valid` pulse carrying the written opcode. The same write while running produces no pulse.
- R10: While `core_rst` is high, the fetch, retire, change-of-flow and software-breakpoint strobes are ignored. Register reads and writes still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rg_wr | input | 1 | Register write strobe |
| rg_rd | input | 1 | Register read strobe |
| rg_addr | input | 4 | Register offset |
| rg_wdata | input | 32 | Write data |
| rg_rdata | output | 32 | Read data, valid the cycle after `rg_rd` |
| core_rst | input | 1 | Core is held in reset |
| fetch_valid | input | 1 | Fetch address strobe |
| fetch_addr | input | 32 | Fetch address |
| retire | input | 1 | One instruction retired |
| cof_valid | input | 1 | Taken change of flow |
| cof_target | input | 32 | Change-of-flow target address |
| swbp_hit | input | 1 | Core decoded a software breakpoint |
| core_clk_en | output | 1 | Clock enable for the core |
| periph_clk_en | output | 1 | Clock enable for the core's peripherals |
| inj_valid | output | 1 | Injected opcode valid |
| inj_opcode | output | 16 | Injected opcode |

## Verification
The assertions assume that every strobe is a clean single-cycle level, sampled at the rising edge. They also assume that at most one register access (read or write) is presented per cycle. The assertions also assume that the core raises `retire` only while its clock enable is high. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It issues accesses strictly one after another through its read and write tasks, and it pulses `retire` only while the core is running, except in the checks that deliberately test halted or reset-time strobes.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam logic [3:0] OFF_CMD    = 4'd0;
  localparam logic [3:0] OFF_STEP   = 4'd1;
  localparam logic [3:0] OFF_BPEN   = 4'd2;
  localparam logic [3:0] OFF_STAT   = 4'd3;
  localparam logic [3:0] OFF_TRACE  = 4'd4;
  localparam logic [3:0] OFF_INJECT = 4'd5;

  localparam int CMD_HALT   = 0;
  localparam int CMD_RESUME = 1;
  localparam int CMD_STEP   = 2;
  localparam int CMD_FLUSH  = 3;
endpackage

// File: rtl/dbg_trace_fifo.sv
module dbg_trace_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [AW-1:0]                push_data,
  input  logic                         pop,
  output logic [AW-1:0]                q,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         wrap
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, do_pop;

  assign full   = (count == CW'(DEPTH));
  assign do_pop = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      wrap   <= 1'b0;
      q      <= '0;
    end else begin
      if (pop) q <= do_pop ? mem[rd_ptr] : '0;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
        wrap   <= 1'b0;
      end else begin
        if (push) wr_ptr <= wr_ptr + 1'b1;
        if (do_pop || (push && full)) rd_ptr <= rd_ptr + 1'b1;
        case ({push, do_pop})
          2'b10: if (full) wrap <= 1'b1; else count <= count + 1'b1;
          2'b01: count <= count - 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R6: occupancy never exceeds capacity
  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R6: a pop without a push lowers the count by one
  p_pop_dec_r6: assert property (@(posedge clk) disable iff (rst)
    (do_pop && !push && !flush) |=> (count == $past(count) - 1'b1));

  // R7: an overrun of a full store raises the wrap flag
  p_wrap_on_overrun_r7: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> wrap);
endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match #(
  parameter int NBP = 2,
  parameter int AW  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [2:0]              wr_idx,
  input  logic [AW-1:0]           wr_data,
  input  logic [NBP-1:0]          en_mask,
  input  logic                    probe,
  input  logic [AW-1:0]           probe_addr,
  output logic [NBP-1:0][AW-1:0]  bp_addr,
  output logic                    hit
);
  logic [NBP-1:0] hits;

  for (genvar i = 0; i < NBP; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) bp_addr[i] <= '0;
      else if (wr_en && wr_idx == 3'(i)) bp_addr[i] <= wr_data;
    end
    assign hits[i] = probe && en_mask[i] && (probe_addr == bp_addr[i]);
  end

  assign hit = |hits;
endmodule

// File: rtl/dbg_step_ctl.sv
module dbg_step_ctl #(
  parameter int SCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [SCW-1:0] load_val,
  input  logic           arm,
  input  logic           retire_ok,
  output logic [SCW-1:0] cnt,
  output logic           armed,
  output logic           done
);
  assign done = armed && retire_ok && (cnt == SCW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
    end else begin
      if (arm && cnt != '0) armed <= 1'b1;
      if (armed && retire_ok) begin
        cnt <= cnt - 1'b1;
        if (done) armed <= 1'b0;
      end
    end
  end

  // R8: the count only moves while armed
  p_cnt_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (!armed && !load) |=> $stable(cnt));
endmodule

// File: rtl/dbg_trace_step.sv
module dbg_trace_step
  import dbg_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IW    = 16,
  parameter int SCW   = 16,
  parameter int DEPTH = 8,
  parameter int NBP   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rg_wr,
  input  logic          rg_rd,
  input  logic [3:0]    rg_addr,
  input  logic [31:0]   rg_wdata,
  output logic [31:0]   rg_rdata,
  input  logic          core_rst,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          retire,
  input  logic          cof_valid,
  input  logic [AW-1:0] cof_target,
  input  logic          swbp_hit,
  output logic          core_clk_en,
  output logic          periph_clk_en,
  output logic          inj_valid,
  output logic [IW-1:0] inj_opcode
);
  localparam int CW = $clog2(DEPTH+1);

  logic                   halted_q, halted_d, core_live;
  logic                   wr_cmd, wr_step, wr_bpen, wr_bp, wr_inj;
  logic                   enter, leave, bp_hit, step_done, step_armed;
  logic [SCW-1:0]         step_cnt;
  logic [NBP-1:0]         bpen_q;
  logic [NBP-1:0][AW-1:0] bp_addr;
  logic [AW-1:0]          fifo_q;
  logic [CW-1:0]          fifo_cnt;
  logic                   fifo_wrap, trace_sel_q;
  logic [31:0]            rdata_q, status;

  assign core_live = !halted_q && !core_rst;
  assign wr_cmd    = rg_wr && rg_addr == OFF_CMD;
  assign wr_step   = rg_wr && rg_addr == OFF_STEP;
  assign wr_bpen   = rg_wr && rg_addr == OFF_BPEN;
  assign wr_inj    = rg_wr && rg_addr == OFF_INJECT;
  assign wr_bp     = rg_wr && rg_addr[3];

  dbg_bp_match #(.NBP(NBP), .AW(AW)) u_bp (
    .clk(clk), .rst(rst), .wr_en(wr_bp), .wr_idx(rg_addr[2:0]),
    .wr_data(rg_wdata[AW-1:0]), .en_mask(bpen_q),
    .probe(fetch_valid && core_live), .probe_addr(fetch_addr),
    .bp_addr(bp_addr), .hit(bp_hit)
  );

  dbg_step_ctl #(.SCW(SCW)) u_step (
    .clk(clk), .rst(rst), .load(wr_step), .load_val(rg_wdata[SCW-1:0]),
    .arm(wr_cmd && rg_wdata[CMD_STEP] && halted_q),
    .retire_ok(retire && core_live),
    .cnt(step_cnt), .armed(step_armed), .done(step_done)
  );

  dbg_trace_fifo #(.DEPTH(DEPTH), .AW(AW)) u_fifo (
    .clk(clk), .rst(rst), .flush(wr_cmd && rg_wdata[CMD_FLUSH]),
    .push(cof_valid && core_live), .push_data(cof_target),
    .pop(rg_rd && rg_addr == OFF_TRACE),
    .q(fifo_q), .count(fifo_cnt), .wrap(fifo_wrap)
  );

  assign enter = (wr_cmd && rg_wdata[CMD_HALT]) || bp_hit
               || (swbp_hit && core_live) || step_done;
  assign leave = wr_cmd && (rg_wdata[CMD_RESUME]
               || (rg_wdata[CMD_STEP] && halted_q && step_cnt != '0));

  always_comb begin
    halted_d = halted_q;
    if (enter)      halted_d = 1'b1;
    else if (leave) halted_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q      <= 1'b0;
      core_clk_en   <= 1'b1;
      periph_clk_en <= 1'b1;
      bpen_q        <= '0;
      inj_valid     <= 1'b0;
      inj_opcode    <= '0;
    end else begin
      halted_q      <= halted_d;
      core_clk_en   <= !halted_d;
      periph_clk_en <= !halted_d;
      if (wr_bpen) bpen_q <= rg_wdata[NBP-1:0];
      inj_valid <= wr_inj && halted_q;
      if (wr_inj && halted_q) inj_opcode <= rg_wdata[IW-1:0];
    end
  end

  always_comb begin
    status = '0;
    status[0] = halted_q;
    status[1] = step_armed;
    status[2] = fifo_wrap;
    status[4 +: CW] = fifo_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q     <= '0;
      trace_sel_q <= 1'b0;
    end else if (rg_rd) begin
      trace_sel_q <= (rg_addr == OFF_TRACE);
      rdata_q     <= '0;
      case (rg_addr)
        OFF_STEP: rdata_q[SCW-1:0] <= step_cnt;
        OFF_BPEN: rdata_q[NBP-1:0] <= bpen_q;
        OFF_STAT: rdata_q <= status;
        default: begin
          for (int i = 0; i < NBP; i++)
            if (rg_addr[3] && rg_addr[2:0] == 3'(i)) rdata_q[AW-1:0] <= bp_addr[i];
        end
      endcase
    end
  end

  assign rg_rdata = trace_sel_q ? 32'(fifo_q) : rdata_q;

  // R3: a comparator match stops the core at the next edge
  p_bp_halts_r3: assert property (@(posedge clk) disable iff (rst)
    bp_hit |=> (halted_q && !core_clk_en));

  // R8: the last stepped retire stops the core
  p_step_halts_r8: assert property (@(posedge clk) disable iff (rst)
    step_done |=> !core_clk_en);

  // R2: core and peripheral enables never disagree
  p_enables_agree_r2: assert property (@(posedge clk) disable iff (rst)
    core_clk_en == periph_clk_en);

  // R9: an injected opcode only appears while the core is stopped
  p_inject_halted_r9: assert property (@(posedge clk) disable iff (rst)
    inj_valid |-> !core_clk_en);
endmodule

// File: tb/tb_dbg_trace_step.sv
module tb_dbg_trace_step;
  logic        clk = 1'b0;
  logic        rst;
  logic        rg_wr, rg_rd, core_rst, fetch_valid, retire, cof_valid, swbp_hit;
  logic [3:0]  rg_addr;
  logic [31:0] rg_wdata, rg_rdata, fetch_addr, cof_target;
  logic        core_clk_en, periph_clk_en, inj_valid;
  logic [15:0] inj_opcode;
  int          total = 0;
  int          bad   = 0;

  always #5 clk = ~clk;

  dbg_trace_step dut (
    .clk(clk), .rst(rst), .rg_wr(rg_wr), .rg_rd(rg_rd), .rg_addr(rg_addr),
    .rg_wdata(rg_wdata), .rg_rdata(rg_rdata), .core_rst(core_rst),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .retire(retire),
    .cof_valid(cof_valid), .cof_target(cof_target), .swbp_hit(swbp_hit),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .inj_valid(inj_valid), .inj_opcode(inj_opcode)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); rg_wr = 1'b1; rg_addr = a; rg_wdata = d;
    @(negedge clk); rg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rg_rd = 1'b1; rg_addr = a;
    @(negedge clk); rg_rd = 1'b0; d = rg_rdata;
  endtask

  task automatic fetch(input logic [31:0] a);
    @(negedge clk); fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk); fetch_valid = 1'b0;
  endtask

  task automatic cof(input logic [31:0] a);
    @(negedge clk); cof_valid = 1'b1; cof_target = a;
    @(negedge clk); cof_valid = 1'b0;
  endtask

  task automatic ret1();
    @(negedge clk); retire = 1'b1;
    @(negedge clk); retire = 1'b0;
  endtask

  task automatic swbp();
    @(negedge clk); swbp_hit = 1'b1;
    @(negedge clk); swbp_hit = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check({31'd0, core_clk_en}, 32'd1, "R1 core_clk_en");
    check({31'd0, periph_clk_en}, 32'd1, "R1 periph_clk_en");
    check({31'd0, inj_valid}, 32'd0, "R1 inj_valid");
    rd(4'd3, v); check(v, 32'd0, "R1 status");
    rd(4'd1, v); check(v, 32'd0, "R1 step count");
    rd(4'd2, v); check(v, 32'd0, "R1 enable mask");
  endtask

  task automatic t_halt();
    logic [31:0] v;
    wr(4'd0, 32'h1);
    check({30'd0, core_clk_en, periph_clk_en}, 32'd0, "R2 enables drop");
    rd(4'd3, v); check(v & 32'h1, 32'h1, "R2 status halted");
    wr(4'd0, 32'h2);
    check({30'd0, core_clk_en, periph_clk_en}, 32'd3, "R2 enables restore");
    wr(4'd0, 32'h3);
    check({31'd0, core_clk_en}, 32'd0, "R2 halt wins over resume");
    wr(4'd0, 32'h2);
  endtask

  task automatic t_bp();
    logic [31:0] v;
    wr(4'd8, 32'h0000_1000);
    wr(4'd9, 32'h0000_2000);
    rd(4'd9, v); check(v, 32'h0000_2000, "R3 comparator 1 readback");
    fetch(32'h1000);
    check({31'd0, core_clk_en}, 32'd1, "R3 disabled comparator ignored");
    wr(4'd2, 32'h1);
    fetch(32'h0FFC);
    check({31'd0, core_clk_en}, 32'd1, "R3 mismatch ignored");
    fetch(32'h1000);
    check({30'd0, core_clk_en, periph_clk_en}, 32'd0, "R3 comparator 0 halts");
    wr(4'd0, 32'h2);
    wr(4'd2, 32'h2);
    fetch(32'h1000);
    check({31'd0, core_clk_en}, 32'd1, "R3 comparator 0 now disabled");
    fetch(32'h2000);
    check({31'd0, core_clk_en}, 32'd0, "R3 comparator 1 halts");
    wr(4'd2, 32'h0);
    wr(4'd0, 32'h2);
  endtask

  task automatic t_swbp();
    swbp();
    check({31'd0, core_clk_en}, 32'd0, "R4 software breakpoint halts");
    wr(4'd0, 32'h2);
  endtask

  task automatic t_trace();
    logic [31:0] v;
    ret1(); ret1();
    rd(4'd3, v); check((v >> 4) & 32'hF, 32'd0, "R5 retire alone pushes nothing");
    cof(32'h100); ret1(); cof(32'h200); cof(32'h300);
    wr(4'd0, 32'h1);
    cof(32'h999);
    wr(4'd0, 32'h2);
    rd(4'd3, v); check((v >> 4) & 32'hF, 32'd3, "R5 R6 count after pushes");
    rd(4'd4, v); check(v, 32'h100, "R6 oldest first");
    rd(4'd4, v); check(v, 32'h200, "R6 second entry");
    rd(4'd3, v); check((v >> 4) & 32'hF, 32'd1, "R6 count after pops");
    rd(4'd4, v); check(v, 32'h300, "R6 third entry, halted push dropped");
    rd(4'd4, v); check(v, 32'h0, "R6 empty pop returns zero");
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    for (int i = 0; i < 10; i++) cof(32'hA0 + 32'(i));
    rd(4'd3, v); check(v & 32'hF4, 32'h84, "R7 full count and wrap flag");
    rd(4'd4, v); check(v, 32'hA2, "R7 oldest two overwritten");
    rd(4'd3, v); check(v & 32'h4, 32'h4, "R7 wrap sticky after pop");
    wr(4'd0, 32'h8);
    rd(4'd3, v); check(v & 32'hF4, 32'h0, "R7 clear empties and clears wrap");
  endtask

  task automatic t_step();
    logic [31:0] v;
    wr(4'd0, 32'h1);
    wr(4'd1, 32'd0);
    wr(4'd0, 32'h4);
    check({31'd0, core_clk_en}, 32'd0, "R8 zero count step ignored");
    wr(4'd1, 32'd3);
    ret1();
    rd(4'd1, v); check(v, 32'd3, "R8 halted retire does not count");
    wr(4'd0, 32'h4);
    check({31'd0, core_clk_en}, 32'd1, "R8 step resumes");
    rd(4'd3, v); check(v & 32'h3, 32'h2, "R8 armed flag");
    ret1(); ret1();
    check({31'd0, core_clk_en}, 32'd1, "R8 still running after two");
    rd(4'd1, v); check(v, 32'd1, "R8 remaining count");
    ret1();
    check({31'd0, core_clk_en}, 32'd0, "R8 halts after third retire");
    rd(4'd3, v); check(v & 32'h3, 32'h1, "R8 armed clears on halt");
  endtask

  task automatic t_inject();
    wr(4'd5, 32'h0000_BEEF);
    check({15'd0, inj_valid, inj_opcode}, 32'h1_BEEF, "R9 inject while halted");
    @(negedge clk);
    check({31'd0, inj_valid}, 32'd0, "R9 pulse lasts one cycle");
    wr(4'd0, 32'h2);
    wr(4'd5, 32'h0000_1234);
    check({31'd0, inj_valid}, 32'd0, "R9 inject while running ignored");
  endtask

  task automatic t_corerst();
    logic [31:0] v;
    wr(4'd8, 32'h0000_3000);
    wr(4'd2, 32'h1);
    @(negedge clk); core_rst = 1'b1;
    fetch(32'h3000);
    swbp();
    cof(32'h777);
    check({31'd0, core_clk_en}, 32'd1, "R10 strobes ignored in reset");
    wr(4'd1, 32'd42);
    rd(4'd1, v); check(v, 32'd42, "R10 register access in reset");
    rd(4'd3, v); check((v >> 4) & 32'hF, 32'd0, "R10 no trace in reset");
    @(negedge clk); core_rst = 1'b0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; rg_wr = 0; rg_rd = 0; rg_addr = 0; rg_wdata = 0;
    core_rst = 0; fetch_valid = 0; fetch_addr = 0; retire = 0;
    cof_valid = 0; cof_target = 0; swbp_hit = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_halt();
    t_bp();
    t_swbp();
    t_trace();
    t_wrap();
    t_step();
    t_inject();
    t_corerst();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule